// File: doc/BRIEF.md
# Watchdog Timer with Keyed Restart

The block is a 32-bit down-counting watchdog on a simple word-addressed register bus. Software loads a reload value and arms the counter by writing one exact key word to a restart register. Any other value written there has no effect, so a stray write cannot keep a hung system alive. When enabled, the counter steps down either on every clock or only on an external 1 MHz strobe.

When the count reaches zero, the block sets a sticky timeout status bit and clears its own enable bit. If reset-on-timeout is enabled, it also raises one of three reset requests (SoC, chip or CPU) for a programmable number of clocks. In SoC mode, the pulse also drives a per-peripheral reset vector taken from a mask register. Distributing the resets is left to the logic around the block.

Top module: `wdog_keyed`

## Requirements
- R1: Registers sit at word offsets 0 counter (read only), 1 reload, 2 restart (reads 0), 3 control, 4 timeout status (bit 0), 5 status clear (reads 0), 6 reset width, 7 reset mask. Read data appears on `bus_rdata` one clock after `bus_rd` and holds until the next read.
- R2: A write of exactly 0x00004755 to offset 2 copies the reload register into the counter. Any other value written to offset 2 changes nothing.
- R3: Control bit 0 is count enable, bit 1 is reset-on-timeout, bit 4 is tick select, bits 6:5 are the reset mode and bit 7 is a stored boot flag. Bits 3:2 and 31:8 read as 0.
- R4: While enabled, the counter decreases by one per step. A step is every clock when bit 4 is 0, and only on clocks with `tick_1us` high when bit 4 is 1. With enable clear, the counter holds.
- R5: From a reload of N ≥ 1, the counter reaches 0 and fires on the Nth step. A count of 0 fires on the next step. After firing, the counter stays at 0.
- R6: On firing, the timeout status bit becomes 1 and control bit 0 becomes 0 at the same clock edge.
- R7: If bit 1 was set when firing, the request chosen by the mode (0 SoC, 1 chip, 2 CPU) is high for `width` clocks, with 0 counted as 1, starting the clock after the firing edge. Mode 3 raises no request, and at most one request is high at a time.
- R8: During a mode-0 pulse, `periph_rst` equals the 26-bit mask held at firing. At all other times it is 0. The mask register keeps only bits 25:0.
- R9: Any write to offset 5 clears the timeout status, unless a firing in the same clock sets it.
- R10: A valid restart in the same clock as a step wins over the step. Restarting more often than the reload span prevents any firing.
- R11: With bit 1 clear, firing still sets the status and clears enable, but raises no request and no peripheral reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1us | input | 1 | One-clock strobe at 1 MHz |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| rst_soc_req | output | 1 | SoC reset request pulse |
| rst_chip_req | output | 1 | Full-chip reset request pulse |
| rst_cpu_req | output | 1 | CPU reset request pulse |
| periph_rst | output | 26 | Per-peripheral reset vector during a SoC pulse |

## Verification
Register writes, restarts and counter steps take effect at the clock edge that samples them. Read data is due one clock after the read strobe. A reset request rises one clock after the edge on which the count reaches zero and stays high for exactly the programmed width. The bench drives inputs on the falling edge and updates a behavioural model on the rising edge. It compares the request outputs and peripheral vector on every falling edge, and compares read data on the falling edge right after the read's sampling edge, so every comparison lands in the cycle its result is due.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int DATA_W = 32;

  typedef enum logic [2:0] {
    REG_COUNT  = 3'd0,
    REG_RELOAD = 3'd1,
    REG_KICK   = 3'd2,
    REG_CTRL   = 3'd3,
    REG_STAT   = 3'd4,
    REG_CLR    = 3'd5,
    REG_WIDTH  = 3'd6,
    REG_MASK   = 3'd7
  } reg_idx_e;

  typedef enum logic [1:0] {
    MODE_SOC  = 2'd0,
    MODE_CHIP = 2'd1,
    MODE_CPU  = 2'd2,
    MODE_NONE = 2'd3
  } rmode_e;

  typedef struct packed {
    logic   boot2;
    rmode_e mode;
    logic   sel_tick;
    logic   rst_en;
    logic   en;
  } ctl_t;

  function automatic ctl_t ctl_from_word(logic [DATA_W-1:0] w);
    ctl_t c;
    c.en       = w[0];
    c.rst_en   = w[1];
    c.sel_tick = w[4];
    c.mode     = rmode_e'(w[6:5]);
    c.boot2    = w[7];
    return c;
  endfunction

  function automatic logic [DATA_W-1:0] ctl_to_word(ctl_t c);
    return {24'd0, c.boot2, c.mode, c.sel_tick, 2'b00, c.rst_en, c.en};
  endfunction
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int WID_W  = 8,
  parameter int MASK_W = 26,
  parameter logic [DATA_W-1:0] KEY = 32'h0000_4755
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [2:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              fire,
  input  logic [CNT_W-1:0]  cnt_val,
  output logic [CNT_W-1:0]  reload_q,
  output ctl_t              ctl_q,
  output logic [WID_W-1:0]  width_q,
  output logic [MASK_W-1:0] mask_q,
  output logic              kick,
  output logic [DATA_W-1:0] rdata_q
);
  reg_idx_e          idx;
  logic              stat_q;
  logic              clr_hit;
  logic [DATA_W-1:0] rd_mux;

  assign idx     = reg_idx_e'(bus_addr);
  assign kick    = bus_wr && (idx == REG_KICK) && (bus_wdata == KEY);
  assign clr_hit = bus_wr && (idx == REG_CLR);

  always_ff @(posedge clk) begin
    if (rst) begin
      reload_q <= '0;
      ctl_q    <= '0;
      width_q  <= '0;
      mask_q   <= '0;
    end else begin
      if (bus_wr) begin
        case (idx)
          REG_RELOAD: reload_q <= bus_wdata[CNT_W-1:0];
          REG_CTRL:   ctl_q    <= ctl_from_word(bus_wdata);
          REG_WIDTH:  width_q  <= bus_wdata[WID_W-1:0];
          REG_MASK:   mask_q   <= bus_wdata[MASK_W-1:0];
          default: ;
        endcase
      end
      if (fire) ctl_q.en <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          stat_q <= 1'b0;
    else if (fire)    stat_q <= 1'b1;
    else if (clr_hit) stat_q <= 1'b0;
  end

  always_comb begin
    case (idx)
      REG_COUNT:  rd_mux = DATA_W'(cnt_val);
      REG_RELOAD: rd_mux = DATA_W'(reload_q);
      REG_CTRL:   rd_mux = ctl_to_word(ctl_q);
      REG_STAT:   rd_mux = DATA_W'(stat_q);
      REG_WIDTH:  rd_mux = DATA_W'(width_q);
      REG_MASK:   rd_mux = DATA_W'(mask_q);
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_mux;
  end

  // R6: firing leaves status set and enable cleared
  p_fire_status_r6: assert property (@(posedge clk) disable iff (rst)
    fire |=> stat_q);
  p_fire_disable_r6: assert property (@(posedge clk) disable iff (rst)
    fire |=> !ctl_q.en);
  // R9: a clear write without a concurrent firing leaves status low
  p_clear_status_r9: assert property (@(posedge clk) disable iff (rst)
    (clr_hit && !fire) |=> !stat_q);
endmodule

// File: rtl/wdt_count.sv
module wdt_count #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             sel_tick,
  input  logic             tick,
  input  logic             kick,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] cnt_q,
  output logic             fire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic step;
  logic last;

  assign step = en && (sel_tick ? tick : 1'b1) && !kick;
  assign last = (cnt_q <= ONE);
  assign fire = step && last;

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (kick) cnt_q <= reload;
    else if (step) cnt_q <= last ? '0 : cnt_q - ONE;
  end

  // R2: a keyed restart loads the reload value
  p_kick_load_r2: assert property (@(posedge clk) disable iff (rst)
    kick |=> (cnt_q == $past(reload)));
  // R4: a step above one decrements by exactly one
  p_step_dec_r4: assert property (@(posedge clk) disable iff (rst)
    (step && !last) |=> (cnt_q == $past(cnt_q) - ONE));
  // R4: without step or restart the count holds
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!step && !kick) |=> $stable(cnt_q));
  // R5: after firing the count is zero
  p_fire_zero_r5: assert property (@(posedge clk) disable iff (rst)
    fire |=> (cnt_q == '0));
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse
  import wdt_pkg::*;
#(
  parameter int WID_W  = 8,
  parameter int MASK_W = 26
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire,
  input  logic              rst_en,
  input  rmode_e            mode,
  input  logic [WID_W-1:0]  width,
  input  logic [MASK_W-1:0] mask,
  output logic              soc_q,
  output logic              chip_q,
  output logic              cpu_q,
  output logic [MASK_W-1:0] periph_q
);
  localparam logic [WID_W-1:0] W_ONE = WID_W'(1);

  logic [WID_W-1:0] left_q;
  logic [WID_W-1:0] w_eff;
  logic             start;

  assign w_eff = (width == '0) ? W_ONE : width;
  assign start = fire && rst_en && (mode != MODE_NONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q   <= '0;
      soc_q    <= 1'b0;
      chip_q   <= 1'b0;
      cpu_q    <= 1'b0;
      periph_q <= '0;
    end else if (start) begin
      left_q   <= w_eff;
      soc_q    <= (mode == MODE_SOC);
      chip_q   <= (mode == MODE_CHIP);
      cpu_q    <= (mode == MODE_CPU);
      periph_q <= (mode == MODE_SOC) ? mask : '0;
    end else if (left_q != '0) begin
      left_q <= left_q - W_ONE;
      if (left_q == W_ONE) begin
        soc_q    <= 1'b0;
        chip_q   <= 1'b0;
        cpu_q    <= 1'b0;
        periph_q <= '0;
      end
    end
  end

  // R7: never more than one request at a time
  p_onehot_req_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({soc_q, chip_q, cpu_q}));
  // R7: an armed firing with a real mode raises a request next cycle
  p_start_req_r7: assert property (@(posedge clk) disable iff (rst)
    start |=> (soc_q || chip_q || cpu_q));
  // R8: peripheral resets only accompany a SoC request
  p_periph_soc_r8: assert property (@(posedge clk) disable iff (rst)
    (periph_q != '0) |-> soc_q);
  // R11: firing without reset enable starts no new pulse
  p_no_arm_r11: assert property (@(posedge clk) disable iff (rst)
    (fire && !rst_en && !(soc_q || chip_q || cpu_q)) |=> !(soc_q || chip_q || cpu_q));
endmodule

// File: rtl/wdog_keyed.sv
module wdog_keyed
  import wdt_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int WID_W  = 8,
  parameter int MASK_W = 26,
  parameter logic [31:0] KEY = 32'h0000_4755
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_1us,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [2:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              rst_soc_req,
  output logic              rst_chip_req,
  output logic              rst_cpu_req,
  output logic [MASK_W-1:0] periph_rst
);
  logic [CNT_W-1:0]  reload;
  logic [CNT_W-1:0]  cnt;
  ctl_t              ctl;
  logic [WID_W-1:0]  width;
  logic [MASK_W-1:0] mask;
  logic              kick;
  logic              fire;

  wdt_regs #(
    .CNT_W(CNT_W), .WID_W(WID_W), .MASK_W(MASK_W), .KEY(KEY)
  ) u_regs (
    .clk(clk), .rst(rst),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .fire(fire), .cnt_val(cnt),
    .reload_q(reload), .ctl_q(ctl), .width_q(width), .mask_q(mask),
    .kick(kick), .rdata_q(bus_rdata)
  );

  wdt_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst(rst),
    .en(ctl.en), .sel_tick(ctl.sel_tick), .tick(tick_1us),
    .kick(kick), .reload(reload),
    .cnt_q(cnt), .fire(fire)
  );

  wdt_pulse #(.WID_W(WID_W), .MASK_W(MASK_W)) u_pulse (
    .clk(clk), .rst(rst),
    .fire(fire), .rst_en(ctl.rst_en), .mode(ctl.mode),
    .width(width), .mask(mask),
    .soc_q(rst_soc_req), .chip_q(rst_chip_req), .cpu_q(rst_cpu_req),
    .periph_q(periph_rst)
  );
endmodule

// File: tb/wdog_keyed_test.sv
module wdog_keyed_test;
  localparam logic [31:0] KEY = 32'h0000_4755;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_1us = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic        rst_soc_req, rst_chip_req, rst_cpu_req;
  logic [25:0] periph_rst;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  int div    = 0;

  // behavioural reference state
  longint unsigned m_cnt, m_reload;
  logic [31:0] m_ctl, m_width, m_mask, m_msk, m_rdata;
  int  m_stat, m_left, m_sel;
  bit  m_kick, m_step, m_fire;

  wdog_keyed uut (
    .clk(clk), .rst(rst), .tick_1us(tick_1us),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .rst_soc_req(rst_soc_req), .rst_chip_req(rst_chip_req), .rst_cpu_req(rst_cpu_req),
    .periph_rst(periph_rst)
  );

  always #4 clk = ~clk;

  always @(negedge clk) begin
    div = (div == 4) ? 0 : div + 1;
    tick_1us = (div == 0);
  end

  function automatic logic [31:0] view(int a);
    case (a)
      0: return m_cnt[31:0];
      1: return m_reload[31:0];
      3: return m_ctl;
      4: return m_stat;
      6: return m_width;
      7: return m_mask;
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_reload = 0; m_ctl = 0; m_stat = 0; m_width = 0;
      m_mask = 0; m_left = 0; m_sel = 0; m_msk = 0; m_rdata = 0;
    end else begin
      if (bus_rd) m_rdata = view(int'(bus_addr));
      m_kick = bus_wr && bus_addr == 3'd2 && bus_wdata == KEY;
      m_step = m_ctl[0] && (m_ctl[4] ? tick_1us : 1'b1) && !m_kick;
      m_fire = m_step && m_cnt <= 1;
      if (m_left > 0) m_left = m_left - 1;
      if (m_fire && m_ctl[1] && m_ctl[6:5] != 2'd3) begin
        m_left = (m_width == 0) ? 1 : int'(m_width);
        m_sel  = int'(m_ctl[6:5]);
        m_msk  = m_mask;
      end
      if (m_kick) m_cnt = m_reload;
      else if (m_step) m_cnt = (m_cnt <= 1) ? 0 : m_cnt - 1;
      if (bus_wr) begin
        case (bus_addr)
          3'd1: m_reload = bus_wdata;
          3'd3: m_ctl    = bus_wdata & 32'h0000_00F3;
          3'd5: m_stat   = 0;
          3'd6: m_width  = bus_wdata & 32'h0000_00FF;
          3'd7: m_mask   = bus_wdata & 32'h03FF_FFFF;
          default: ;
        endcase
      end
      if (m_fire) begin
        m_ctl[0] = 1'b0;
        m_stat   = 1;
      end
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // request outputs and peripheral vector, compared every cycle
  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R7 request lines", {29'd0, rst_soc_req, rst_chip_req, rst_cpu_req},
            {29'd0, m_left > 0 && m_sel == 0, m_left > 0 && m_sel == 1, m_left > 0 && m_sel == 2});
      check("R8 peripheral vector", {6'd0, periph_rst},
            (m_left > 0 && m_sel == 0) ? m_msk : 32'd0);
    end
  end

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a[2:0]; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = 32'd0;
  endtask

  task automatic rd(int a, string req);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a[2:0];
    @(negedge clk);
    bus_rd = 1'b0;
    check(req, bus_rdata, m_rdata);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    for (int a = 0; a < 8; a++) rd(a, "R1 reset value");

    // control field packing
    wr(3, 32'hFFFF_FF72); rd(3, "R3 control bits");
    wr(3, 32'h0000_0080); rd(3, "R3 boot flag");

    // restart key
    wr(1, 32'h0000_1234);
    wr(2, 32'h0000_4756); rd(0, "R2 wrong key ignored");
    wr(2, 32'h0001_4755); rd(0, "R2 wide key ignored");
    wr(2, KEY);           rd(0, "R2 key loads reload");
    rd(2, "R1 restart reads zero");
    rd(1, "R1 reload readback");

    // every-clock and tick-paced counting
    wr(3, 32'h0000_0001); idle(7); wr(3, 32'h0); rd(0, "R4 every clock");
    idle(4); rd(0, "R4 holds when disabled");
    wr(3, 32'h0000_0011); idle(23); wr(3, 32'h0); rd(0, "R4 tick paced");

    // CPU reset, width 4, reload 10 on ticks
    wr(6, 32'd4); wr(1, 32'd10); wr(2, KEY);
    wr(3, 32'h0000_0053);
    idle(80);
    rd(3, "R6 enable cleared");
    rd(4, "R6 status set");
    rd(0, "R5 counter parked at zero");
    wr(5, 32'h0); rd(4, "R9 clear status");

    // chip reset, width 0 treated as 1, every clock
    wr(6, 32'd0); wr(1, 32'd3); wr(2, KEY);
    wr(3, 32'h0000_0023); idle(10);
    rd(4, "R7 chip mode fired");

    // SoC reset with peripheral mask
    wr(7, 32'hFFFF_FFFF); rd(7, "R8 mask width");
    wr(7, 32'h0100_0005); wr(6, 32'd2); wr(1, 32'd1); wr(2, KEY);
    wr(3, 32'h0000_0003); idle(10);
    rd(7, "R8 mask held");

    // reserved mode 3
    wr(5, 32'h0); wr(1, 32'd2); wr(2, KEY);
    wr(3, 32'h0000_0063); idle(10);
    rd(4, "R7 mode three status only");

    // reset disabled
    wr(5, 32'h0); wr(6, 32'd5); wr(1, 32'd2); wr(2, KEY);
    wr(3, 32'h0000_0041); idle(10);
    rd(3, "R11 enable cleared without reset");
    rd(4, "R11 status set without reset");

    // repeated restarts keep it alive
    wr(5, 32'h0); wr(1, 32'd6); wr(2, KEY); wr(3, 32'h0000_0043);
    for (int k = 0; k < 6; k++) wr(2, KEY);
    rd(4, "R10 no firing while kicked");
    rd(3, "R10 still enabled");
    wr(3, 32'h0); idle(3);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL R1 watchdog expired actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule